// File: doc/BRIEF.md
# Serial Command Frame Receiver

This block takes in a fixed 56-bit command frame from a three-wire serial link: a select line that frames the transfer, a serial clock and a serial data line. While select is high, every rising edge of the serial clock shifts one data bit into the receiver. Once the last bit has arrived, the receiver checks the trailing CRC byte against a CRC it has computed over the first 48 bits. It then either issues a command to a downstream memory sequencer or reports an abort.

The three serial lines are asynchronous to the system clock. The block synchronises them and finds serial clock edges in the system clock domain. A frame whose check byte matches yields a one-cycle `cmd_valid` strobe, together with the decoded command code and a 19-bit start address. A mismatch yields a one-cycle `crc_error` strobe, and the command and address outputs keep their previous values. The receiver then waits for select to drop before it accepts another frame.

Top module: `cmd_frame_rx`

## Requirements
- R1: While `ser_sel` is low the receiver ignores `ser_clk` and `ser_dat` and issues no strobe. Dropping `ser_sel` at any point discards every bit received so far and clears the CRC, so the next frame starts from bit 0.
- R2: While `ser_sel` is high, one bit of `ser_dat` is captured on each rising edge of `ser_clk`. The first bit captured is frame bit 0 (least significant bit first).
- R3: A frame is exactly 56 bits. No strobe appears after 55 bits, and a strobe appears after the 56th bit.
- R4: Frame bits 0 to 7 are the command code, with bit 0 as its LSB. Bits 8 to 31 are a 24-bit address field, and `start_addr` takes its low 19 bits (frame bits 8 to 26). Frame bits 27 to 47 do not affect any output.
- R5: The check value is CRC-8 with polynomial 0x31 and initial value 0, taken over frame bits 0 to 47 in arrival order. Each step is feedback = crc[7] XOR bit, then crc = (crc << 1) XOR (feedback ? 0x31 : 0). It is compared with frame bits 48 to 55, where frame bit 48 is CRC bit 0.
- R6: On a match, `cmd_valid` pulses and `cmd_code`/`start_addr` take the new frame's fields in the same cycle. On a mismatch, `crc_error` pulses and `cmd_code`/`start_addr` keep their previous values.
- R7: Each completed frame produces exactly one strobe, lasting exactly one system clock. `cmd_valid` and `crc_error` are never high together.
- R8: After a frame completes, further serial clock edges produce no strobe until `ser_sel` has gone low.
- R9: A frame cut short by `ser_sel` going low never produces a strobe.
- R10: After reset, `cmd_valid`, `crc_error`, `cmd_code` and `start_addr` are all zero.
- R11: The strobe appears no later than the fourth system clock edge after the 56th rising edge of `ser_clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_sel | input | 1 | Serial select; high frames a transfer (asynchronous) |
| ser_clk | input | 1 | Serial clock; data captured on its rising edge (asynchronous) |
| ser_dat | input | 1 | Serial data line (asynchronous) |
| cmd_valid | output | 1 | One-cycle strobe: frame received with matching CRC |
| crc_error | output | 1 | One-cycle strobe: frame received with CRC mismatch |
| cmd_code | output | 8 | Command code of the last valid frame |
| start_addr | output | 19 | Start address of the last valid frame |

## Verification
The hardest states to reach from the ports are the edges of the frame counter. These are a frame abandoned partway through and then followed by a fresh one, a frame held at 55 bits before its final bit, and surplus bits clocked in after completion while select stays high. Directed sequences drive each of these. Seeded random frames, about a third of them with one flipped bit at a random position (including the CRC byte itself), then cover the check path. A bench model of the CRC predicts which strobe each frame should produce and which fields it should carry.

// File: rtl/cmd_frame_rx_pkg.sv
package cmd_frame_rx_pkg;

    typedef enum logic {
        ST_RECV = 1'b0,
        ST_HOLD = 1'b1
    } rx_state_e;

    // One serial CRC step, shifting toward the MSB.
    function automatic logic [7:0] crc8_step(input logic [7:0] crc,
                                             input logic       din,
                                             input logic [7:0] poly);
        logic fb;
        fb = crc[7] ^ din;
        return {crc[6:0], 1'b0} ^ (fb ? poly : 8'h00);
    endfunction

endpackage

// File: rtl/frx_sync.sv
module frx_sync #(
    parameter int STAGES = 2,
    parameter int W      = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [W-1:0] stage_d;
        if (g == 0) begin : g_first
            assign stage_d = async_i;
        end else begin : g_next
            assign stage_d = stage_q[g-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[g] <= '0;
            else        stage_q[g] <= stage_d;
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/frx_front.sv
module frx_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_sel,
    input  logic ser_clk,
    input  logic ser_dat,
    output logic sel_o,
    output logic bit_stb_o,
    output logic bit_o
);
    localparam int LINES = 3;

    typedef struct packed {
        logic clk_prev;
    } front_t;

    logic [LINES-1:0] sync_w;
    front_t           f_d, f_q;

    frx_sync #(.STAGES(SYNC_STAGES), .W(LINES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ser_dat, ser_clk, ser_sel}),
        .sync_o  (sync_w)
    );

    always_comb begin
        f_d          = f_q;
        f_d.clk_prev = sync_w[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign sel_o     = sync_w[0];
    assign bit_stb_o = sync_w[0] & sync_w[1] & ~f_q.clk_prev;
    assign bit_o     = sync_w[2];
endmodule

// File: rtl/frx_crc.sv
module frx_crc
    import cmd_frame_rx_pkg::*;
#(
    parameter int         CRC_W = 8,
    parameter logic [7:0] POLY  = 8'h31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic             bit_i,
    output logic [CRC_W-1:0] crc_o
);
    typedef struct packed {
        logic [CRC_W-1:0] crc;
    } crc_t;

    crc_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (clr_i)     c_d.crc = '0;
        else if (en_i) c_d.crc = crc8_step(c_q.crc, bit_i, POLY);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign crc_o = c_q.crc;

    // R1 / R5: a clear request always leaves a zero CRC behind
    a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (crc_o == '0));
endmodule

// File: rtl/frx_ctl.sv
module frx_ctl
    import cmd_frame_rx_pkg::*;
#(
    parameter int FRAME_BITS = 56,
    parameter int CMD_W      = 8,
    parameter int ADDR_LSB   = 8,
    parameter int ADDR_W     = 19,
    parameter int CRC_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              bit_stb_i,
    input  logic              bit_i,
    input  logic [CRC_W-1:0]  crc_i,
    output logic              crc_clr_o,
    output logic              crc_en_o,
    output logic              cmd_valid_o,
    output logic              crc_error_o,
    output logic [CMD_W-1:0]  cmd_code_o,
    output logic [ADDR_W-1:0] start_addr_o
);
    localparam int DATA_BITS = FRAME_BITS - CRC_W;
    localparam int CNT_W     = $clog2(FRAME_BITS + 1);

    typedef struct packed {
        rx_state_e             st;
        logic [CNT_W-1:0]      cnt;
        logic [FRAME_BITS-1:0] shreg;
        logic                  valid;
        logic                  err;
        logic [CMD_W-1:0]      cmd;
        logic [ADDR_W-1:0]     addr;
    } ctl_t;

    ctl_t                  s_d, s_q;
    logic [FRAME_BITS-1:0] full_w;
    logic [CRC_W-1:0]      rx_crc_w;

    assign full_w   = {bit_i, s_q.shreg[FRAME_BITS-1:1]};
    assign rx_crc_w = full_w[FRAME_BITS-1 -: CRC_W];

    always_comb begin
        s_d       = s_q;
        s_d.valid = 1'b0;
        s_d.err   = 1'b0;
        crc_clr_o = 1'b0;
        crc_en_o  = 1'b0;
        if (!sel_i) begin
            s_d.st    = ST_RECV;
            s_d.cnt   = '0;
            crc_clr_o = 1'b1;
        end else if (s_q.st == ST_RECV && bit_stb_i) begin
            s_d.shreg = full_w;
            s_d.cnt   = s_q.cnt + 1'b1;
            crc_en_o  = (s_q.cnt < CNT_W'(DATA_BITS));
            if (s_q.cnt == CNT_W'(FRAME_BITS - 1)) begin
                s_d.st = ST_HOLD;
                if (rx_crc_w == crc_i) begin
                    s_d.valid = 1'b1;
                    s_d.cmd   = full_w[CMD_W-1:0];
                    s_d.addr  = full_w[ADDR_LSB +: ADDR_W];
                end else begin
                    s_d.err = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cmd_valid_o  = s_q.valid;
    assign crc_error_o  = s_q.err;
    assign cmd_code_o   = s_q.cmd;
    assign start_addr_o = s_q.addr;

    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid_o && crc_error_o));
    a_r7_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |=> !cmd_valid_o);
    a_r7_error_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        crc_error_o |=> !crc_error_o);
    a_r1_sel_low_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_i |=> (s_q.cnt == '0));
    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CNT_W'(FRAME_BITS));
    a_r6_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid_o |-> ($stable(cmd_code_o) && $stable(start_addr_o)));
    a_r8_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_HOLD && $past(s_q.st == ST_HOLD)) |-> !(cmd_valid_o || crc_error_o));
endmodule

// File: rtl/cmd_frame_rx.sv
module cmd_frame_rx #(
    parameter int         FRAME_BITS  = 56,
    parameter int         CMD_W       = 8,
    parameter int         ADDR_W      = 19,
    parameter int         CRC_W       = 8,
    parameter logic [7:0] CRC_POLY    = 8'h31,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_sel,
    input  logic              ser_clk,
    input  logic              ser_dat,
    output logic              cmd_valid,
    output logic              crc_error,
    output logic [CMD_W-1:0]  cmd_code,
    output logic [ADDR_W-1:0] start_addr
);
    localparam int ADDR_LSB = CMD_W;

    logic             sel_w, stb_w, bit_w, clr_w, en_w;
    logic [CRC_W-1:0] crc_w;

    frx_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_sel   (ser_sel),
        .ser_clk   (ser_clk),
        .ser_dat   (ser_dat),
        .sel_o     (sel_w),
        .bit_stb_o (stb_w),
        .bit_o     (bit_w)
    );

    frx_crc #(.CRC_W(CRC_W), .POLY(CRC_POLY)) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (clr_w),
        .en_i  (en_w),
        .bit_i (bit_w),
        .crc_o (crc_w)
    );

    frx_ctl #(
        .FRAME_BITS (FRAME_BITS),
        .CMD_W      (CMD_W),
        .ADDR_LSB   (ADDR_LSB),
        .ADDR_W     (ADDR_W),
        .CRC_W      (CRC_W)
    ) u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .sel_i        (sel_w),
        .bit_stb_i    (stb_w),
        .bit_i        (bit_w),
        .crc_i        (crc_w),
        .crc_clr_o    (clr_w),
        .crc_en_o     (en_w),
        .cmd_valid_o  (cmd_valid),
        .crc_error_o  (crc_error),
        .cmd_code_o   (cmd_code),
        .start_addr_o (start_addr)
    );
endmodule

// File: tb/tb_cmd_frame_rx.sv
`timescale 1ns/1ps
module tb_cmd_frame_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_sel = 1'b0, ser_clk = 1'b0, ser_dat = 1'b0;
    logic        cmd_valid, crc_error;
    logic [7:0]  cmd_code;
    logic [18:0] start_addr;

    int n_chk = 0, n_bad = 0;
    int n_val = 0, n_err = 0, n_wide = 0;
    int cyc = 0, last_rise = 0, first_pulse = -1;
    logic prev_pulse = 1'b0;
    logic [7:0]  exp_cmd = '0;
    logic [18:0] exp_addr = '0;
    bit done = 0;

    always #2 clk = ~clk;

    cmd_frame_rx dut (
        .clk(clk), .rst_n(rst_n), .ser_sel(ser_sel), .ser_clk(ser_clk),
        .ser_dat(ser_dat), .cmd_valid(cmd_valid), .crc_error(crc_error),
        .cmd_code(cmd_code), .start_addr(start_addr)
    );

    always @(posedge clk) cyc++;

    always @(negedge clk) begin
        if (rst_n) begin
            if (cmd_valid) n_val++;
            if (crc_error) n_err++;
            if ((cmd_valid || crc_error) && prev_pulse) n_wide++;
            if ((cmd_valid || crc_error) && first_pulse < 0) first_pulse = cyc;
            prev_pulse = cmd_valid | crc_error;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model_crc(input logic [55:0] f);
        logic [7:0] c = 8'h00;
        for (int i = 0; i < 48; i++) begin
            logic fb = c[7] ^ f[i];
            c = {c[6:0], 1'b0};
            if (fb) c = c ^ 8'h31;
        end
        return c;
    endfunction

    function automatic logic [55:0] mk_frame(input logic [7:0] cmd, input logic [23:0] a,
                                             input logic [15:0] rsv);
        logic [55:0] f;
        f[7:0] = cmd; f[31:8] = a; f[47:32] = rsv;
        f[55:48] = model_crc(f);
        return f;
    endfunction

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clr_counts();
        n_val = 0; n_err = 0; first_pulse = -1;
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk); ser_clk = 1'b0; ser_dat = b;
        wclk(3);
        ser_clk = 1'b1; last_rise = cyc;
        wclk(3);
    endtask

    task automatic send_bits(input logic [55:0] f, input int lo, input int hi);
        ser_sel = 1'b1; wclk(4);
        for (int i = lo; i < hi; i++) send_bit(f[i]);
        @(negedge clk); ser_clk = 1'b0;
        wclk(8);
    endtask

    task automatic drop_sel();
        @(negedge clk); ser_sel = 1'b0; ser_clk = 1'b0; wclk(6);
    endtask

    // full frame; predicts result from the bench model
    task automatic full_frame(input logic [55:0] f, input string tag);
        bit good;
        good = (f[55:48] == model_crc(f));
        clr_counts();
        send_bits(f, 0, 56);
        if (good) begin
            exp_cmd = f[7:0]; exp_addr = f[26:8];
        end
        chk(n_val == (good ? 1 : 0), {tag, " R6 cmd_valid count"}, n_val, good ? 1 : 0);
        chk(n_err == (good ? 0 : 1), {tag, " R5 crc_error count"}, n_err, good ? 0 : 1);
        chk(cmd_code == exp_cmd, {tag, " R4 cmd_code"}, cmd_code, exp_cmd);
        chk(start_addr == exp_addr, {tag, " R4 start_addr"}, start_addr, exp_addr);
        chk(first_pulse - last_rise <= 4 && first_pulse >= 0, {tag, " R11 latency"},
            first_pulse - last_rise, 4);
        drop_sel();
    endtask

    initial begin
        logic [55:0] f;
        void'($urandom(32'd1234));
        wclk(3);
        rst_n = 1'b1;
        wclk(2);
        // R10 reset state
        chk(!cmd_valid && !crc_error, "R10 strobes low", {cmd_valid, crc_error}, 0);
        chk(cmd_code == 0 && start_addr == 0, "R10 fields zero", {cmd_code, start_addr}, 0);

        // R2 R4: address field upper bits masked, reserved bits ignored
        full_frame(mk_frame(8'h3C, 24'hF54321, 16'hBEEF), "dir1");
        full_frame(mk_frame(8'h81, 24'h000001, 16'h0000), "dir2");

        // R3: 55 bits give nothing, the 56th completes
        f = mk_frame(8'h5A, 24'h07FFFF, 16'h1234);
        clr_counts();
        send_bits(f, 0, 55);
        chk(n_val + n_err == 0, "R3 no strobe after 55 bits", n_val + n_err, 0);
        send_bits(f, 55, 56);
        exp_cmd = 8'h5A; exp_addr = 19'h7FFFF;
        chk(n_val == 1, "R3 strobe after 56th bit", n_val, 1);
        chk(start_addr == exp_addr, "R3 start_addr", start_addr, exp_addr);

        // R8: surplus bits with select still high
        clr_counts();
        send_bits(mk_frame(8'h11, 24'h22222, 16'h0), 0, 56);
        chk(n_val + n_err == 0, "R8 no strobe after completion", n_val + n_err, 0);
        chk(cmd_code == exp_cmd, "R8 cmd_code unchanged", cmd_code, exp_cmd);
        drop_sel();

        // R1: serial clock toggling with select low
        clr_counts();
        for (int i = 0; i < 70; i++) begin
            @(negedge clk); ser_dat = i[0]; wclk(2); ser_clk = 1'b1; wclk(2); ser_clk = 1'b0;
        end
        wclk(8);
        chk(n_val + n_err == 0, "R1 idle while select low", n_val + n_err, 0);

        // R9 R1: abandoned frame then fresh frame
        clr_counts();
        send_bits(mk_frame(8'hEE, 24'h0ABCDE, 16'h0), 0, 30);
        drop_sel();
        chk(n_val + n_err == 0, "R9 partial frame silent", n_val + n_err, 0);
        full_frame(mk_frame(8'h66, 24'h012345, 16'h0F0F), "R1 restart");

        // R5: only the CRC byte is wrong
        f = mk_frame(8'h99, 24'h054321, 16'h0);
        f[55] = ~f[55];
        full_frame(f, "crcbyte");

        // random frames, some with one flipped bit
        for (int k = 0; k < 40; k++) begin
            f = mk_frame(8'($urandom), 24'($urandom), 16'($urandom));
            if ($urandom_range(0, 2) == 0) f[$urandom_range(0, 55)] ^= 1'b1;
            full_frame(f, "rand");
        end

        chk(n_wide == 0, "R7 strobe width one cycle", n_wide, 0);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule